// File: doc/BRIEF.md
# Sized Memory Access Decoder

This unit sits between a CPU core and the on-chip memories. It accepts one access at a time: a byte, a 16-bit word or a 32-bit long. It carries the access out as a sequence of smaller transfers on three target ports. These are a byte-wide RAM, a byte-wide ROM, and an external device port that takes byte or word transfers. Multi-byte values are big-endian: the most significant part sits at the lowest address.

The 24-bit address space has four regions. An eight-byte window at address zero reads the first eight ROM bytes and ignores writes. The RAM window follows it and runs up to 0x7DFFFF. Only the first `RAM_BYTES` bytes of that window are backed by storage. The ROM window runs from 0x7E0000 to 0x7FFFFF. Every address from 0x800000 upward belongs to the device port. Every sub-transfer is decoded on its own address, so a long access can start in ROM and finish on the device port. A request is answered with a one-cycle done pulse, the read data right-aligned, and an error flag.

Top module: `memacc_unit`

## Requirements
- R1: While reset is held low, and after its release with no request, `rsp_done`, `ram_en`, `rom_en` and `dev_valid` are all 0.
- R2: A read below 0x8 returns the ROM byte whose offset equals the address.
- R3: A write below 0x8, or in 0x7E0000 to 0x7FFFFF, is dropped. No RAM strobe is raised, and a later read returns the unchanged ROM contents.
- R4: An address from 0x8 up to `RAM_BYTES`-1 reaches RAM byte `addr`. A written byte reads back unchanged.
- R5: An address from `RAM_BYTES` up to 0x7DFFFF reads 0xFF in every byte. A write there raises no RAM strobe.
- R6: An address from 0x7E0000 to 0x7FFFFF reads the ROM byte at offset `addr`-0x7E0000.
- R7: A word below 0x800000 is done as two byte transfers. The most significant byte goes to `addr` and the least significant byte to `addr`+1.
- R8: A long is done as two word accesses. The upper half goes to `addr` and the lower half to `addr`+2. Each half is decoded by its own address.
- R9: At or above 0x800000, a word or long half is one device transfer with `dev_word`=1 and 16-bit data. A byte is one transfer with `dev_word`=0, carrying its data in bits 7:0. A transfer holds until `dev_ready` is seen.
- R10: `req_size` encodes 0=byte, 1=word, 2=long. Code 3 gives done together with `rsp_err`=1 in the cycle after the request, with no port strobe. `rsp_err` first rises only together with `rsp_done`.
- R11: `rsp_done` is high for exactly one cycle per request. It comes with `rsp_rdata` right-aligned (byte in 7:0, word in 15:0) and `rsp_err`=0 for a valid size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an access (accepted when idle) |
| req_addr | input | 24 | Access address |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 unsupported |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Unsupported size code |
| rsp_rdata | output | 32 | Read data, right-aligned |
| ram_en | output | 1 | RAM byte strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid the cycle after `ram_en` |
| rom_en | output | 1 | ROM byte strobe |
| rom_addr | output | ROM_AW | ROM byte offset |
| rom_rdata | input | 8 | ROM read byte, valid the cycle after `rom_en` |
| dev_valid | output | 1 | Device transfer request |
| dev_write | output | 1 | Device write |
| dev_word | output | 1 | 1 word transfer, 0 byte transfer |
| dev_addr | output | 24 | Device address |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |
| dev_ready | input | 1 | Device transfer complete |

## Verification
The sizes are exercised against each region. The overlay and the ROM window are read to separate an offset from the address from an offset from the ROM base. Word and long writes to RAM are read back byte by byte and word by word, which catches swapped byte or half order. Reads past the populated RAM separate the 0xFF fill from aliasing into real storage. Device accesses are counted at the port, which tells a single word transfer from a split one. A long that straddles 0x800000 shows that each half is decoded on its own address. The bad size code is checked for latency and for silence on every port.

// File: rtl/memacc_pkg.sv
// Shared constants, types and helpers for the sized memory access decoder.
// Assumes a 24-bit byte address space and big-endian data placement.
package memacc_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] BOOT_END = 24'h000008;
    localparam logic [ADDR_W-1:0] ROM_BASE = 24'h7E0000;
    localparam logic [ADDR_W-1:0] DEV_BASE = 24'h800000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_t;

    typedef enum logic [2:0] {
        RG_BOOT,
        RG_RAM,
        RG_HOLE,
        RG_ROM,
        RG_DEV
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_MEMWAIT,
        ST_DONE
    } state_t;

    // Number of bytes carried by a size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            SZ_LONG: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Byte of right-aligned write data that belongs at byte offset off.
    function automatic logic [7:0] lane_byte(input logic [DATA_W-1:0] d,
                                             input logic [2:0] nb,
                                             input logic [2:0] off);
        int sh;
        sh = 8 * (int'(nb) - 1 - int'(off));
        if (sh < 0) sh = 0;
        return 8'(d >> sh);
    endfunction

    // Word of right-aligned write data that starts at byte offset off.
    function automatic logic [15:0] lane_word(input logic [DATA_W-1:0] d,
                                              input logic [2:0] nb,
                                              input logic [2:0] off);
        int sh;
        sh = 8 * (int'(nb) - 2 - int'(off));
        if (sh < 0) sh = 0;
        return 16'(d >> sh);
    endfunction

endpackage

// File: rtl/memacc_decode.sv
// Address region decoder.
// Maps one byte address to boot overlay, populated RAM, unpopulated RAM
// hole, ROM window or device region. Purely combinational.
// Assumes RAM_BYTES is above the overlay and below the ROM window.
module memacc_decode
    import memacc_pkg::*;
#(
    parameter int RAM_BYTES = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);

    localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_BYTES);

    // Priority compare from the lowest boundary upward.
    always_comb begin
        if (addr < BOOT_END) begin
            region = RG_BOOT;
        end else if (addr < ROM_BASE) begin
            region = (addr < RAM_TOP) ? RG_RAM : RG_HOLE;
        end else if (addr < DEV_BASE) begin
            region = RG_ROM;
        end else begin
            region = RG_DEV;
        end
    end

endmodule

// File: rtl/memacc_pack.sv
// Read data accumulator.
// Shifts each returned byte or word in from the right, so that the first
// sub-transfer (lowest address) ends up most significant.
// Assumes the sequencer clears it before each access.
module memacc_pack
    import memacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              push_wide,
    input  logic [15:0]       val,
    output logic [DATA_W-1:0] acc
);

    // Clear on a new access, otherwise shift in one byte or one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (push) begin
            if (push_wide) begin
                acc <= {acc[DATA_W-17:0], val};
            end else begin
                acc <= {acc[DATA_W-9:0], val[7:0]};
            end
        end
    end

endmodule

// File: rtl/memacc_seq.sv
// Access sequencer.
// Accepts one request when idle and walks a byte offset through it. Each
// step is a byte, or a word when a multi-byte access lands on the device
// region. It finishes with a one-cycle done state.
// Assumes the port stage reports step_wait for local memory strobes and
// step_done when a step finishes.
module memacc_seq
    import memacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  region_t           region,
    input  logic              step_done,
    input  logic              step_wait,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              issue,
    output logic              in_wait,
    output logic              wait_rom,
    output logic              wide,
    output logic              wr,
    output logic [7:0]        wbyte,
    output logic [15:0]       wword,
    output logic              acc_clr,
    output logic              acc_push,
    output logic              acc_wide,
    output logic              rsp_done,
    output logic              rsp_err
);

    state_t            state_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        size_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [2:0]        off_q;
    logic              err_q;
    logic              wait_rom_q;
    logic [2:0]        nbytes;
    logic [2:0]        next_off;
    logic              step_two;

    // Current step address, step width and write lane selection.
    always_comb begin
        nbytes   = size_bytes(size_q);
        cur_addr = base_q + ADDR_W'(off_q);
        issue    = (state_q == ST_STEP);
        in_wait  = (state_q == ST_MEMWAIT);
        wide     = (size_q != SZ_BYTE) && (region == RG_DEV);
        step_two = issue && wide;
        next_off = off_q + (step_two ? 3'd2 : 3'd1);
        wbyte    = lane_byte(wdata_q, nbytes, off_q);
        wword    = lane_word(wdata_q, nbytes, off_q);
        wr       = wr_q;
        wait_rom = wait_rom_q;
        acc_clr  = (state_q == ST_IDLE) && req_valid;
        acc_push = step_done && !wr_q;
        acc_wide = step_two;
        rsp_done = (state_q == ST_DONE);
        rsp_err  = err_q;
    end

    // Request capture, step advance and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            size_q     <= SZ_BYTE;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            off_q      <= '0;
            err_q      <= 1'b0;
            wait_rom_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        off_q <= '0;
                        if (req_size == SZ_BAD) begin
                            err_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= req_addr;
                            size_q  <= req_size;
                            wr_q    <= req_write;
                            wdata_q <= req_wdata;
                            err_q   <= 1'b0;
                            state_q <= ST_STEP;
                        end
                    end
                end
                ST_STEP, ST_MEMWAIT: begin
                    if (issue && step_wait) begin
                        wait_rom_q <= (region != RG_RAM);
                        state_q    <= ST_MEMWAIT;
                    end else if (step_done) begin
                        off_q   <= next_off;
                        state_q <= (next_off >= nbytes) ? ST_DONE : ST_STEP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: a bad size code completes with the error flag one cycle later.
    a_r10_bad_size_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && req_size == 2'd3) |=> (rsp_done && rsp_err));

    // R11: the step offset never runs past the access length.
    a_r11_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (off_q < nbytes));

endmodule

// File: rtl/memacc_port.sv
// Target port stage.
// Turns the current step into a strobe on RAM, ROM or the device port.
// Reports whether the step ends now or needs a memory wait cycle, and
// returns the read value. Purely combinational.
// Assumes RAM and ROM return data the cycle after their strobe.
module memacc_port
    import memacc_pkg::*;
#(
    parameter int RAM_AW = 10,
    parameter int ROM_AW = 17
) (
    input  logic              issue,
    input  logic              in_wait,
    input  logic              wait_rom,
    input  region_t           region,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              wr,
    input  logic              wide,
    input  logic [7:0]        wbyte,
    input  logic [15:0]       wword,
    input  logic [7:0]        ram_rdata,
    input  logic [7:0]        rom_rdata,
    input  logic              dev_ready,
    input  logic [15:0]       dev_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              dev_valid,
    output logic              dev_write,
    output logic              dev_word,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [15:0]       dev_wdata,
    output logic              step_done,
    output logic              step_wait,
    output logic [15:0]       rd_val
);

    // Strobe generation and step outcome for the decoded region.
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = RAM_AW'(cur_addr);
        ram_wdata = wbyte;
        rom_en    = 1'b0;
        rom_addr  = (region == RG_BOOT) ? ROM_AW'(cur_addr)
                                        : ROM_AW'(cur_addr - ROM_BASE);
        dev_valid = 1'b0;
        dev_write = 1'b0;
        dev_word  = 1'b0;
        dev_addr  = cur_addr;
        dev_wdata = wide ? wword : {8'h00, wbyte};
        step_done = 1'b0;
        step_wait = 1'b0;
        rd_val    = 16'h0000;
        if (in_wait) begin
            step_done = 1'b1;
            rd_val    = {8'h00, wait_rom ? rom_rdata : ram_rdata};
        end else if (issue) begin
            case (region)
                RG_BOOT, RG_ROM: begin
                    if (wr) begin
                        step_done = 1'b1;
                    end else begin
                        rom_en    = 1'b1;
                        step_wait = 1'b1;
                    end
                end
                RG_RAM: begin
                    ram_en    = 1'b1;
                    ram_we    = wr;
                    step_wait = 1'b1;
                end
                RG_HOLE: begin
                    step_done = 1'b1;
                    rd_val    = 16'h00FF;
                end
                default: begin
                    dev_valid = 1'b1;
                    dev_write = wr;
                    dev_word  = wide;
                    step_done = dev_ready;
                    rd_val    = wide ? dev_rdata : {8'h00, dev_rdata[7:0]};
                end
            endcase
        end
    end

endmodule

// File: rtl/memacc_unit.sv
// Sized memory access decoder, top level.
// Splits byte, word and long requests into big-endian byte transfers on
// RAM and ROM, and byte or word transfers on the device port, over a
// 24-bit address space. One request is in flight at a time.
// Assumes synchronous RAM/ROM with one cycle of read latency and a device
// that raises dev_ready for the cycle in which a transfer completes.
module memacc_unit
    import memacc_pkg::*;
#(
    parameter int RAM_BYTES = 1024,
    parameter int ROM_AW    = 17,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [23:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_rdata,
    output logic              dev_valid,
    output logic              dev_write,
    output logic              dev_word,
    output logic [23:0]       dev_addr,
    output logic [15:0]       dev_wdata,
    input  logic [15:0]       dev_rdata,
    input  logic              dev_ready
);

    logic [ADDR_W-1:0] cur_addr;
    region_t           region;
    logic              issue;
    logic              in_wait;
    logic              wait_rom;
    logic              wide;
    logic              wr;
    logic [7:0]        wbyte;
    logic [15:0]       wword;
    logic              acc_clr;
    logic              acc_push;
    logic              acc_wide;
    logic              step_done;
    logic              step_wait;
    logic [15:0]       rd_val;

    memacc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .region    (region),
        .step_done (step_done),
        .step_wait (step_wait),
        .cur_addr  (cur_addr),
        .issue     (issue),
        .in_wait   (in_wait),
        .wait_rom  (wait_rom),
        .wide      (wide),
        .wr        (wr),
        .wbyte     (wbyte),
        .wword     (wword),
        .acc_clr   (acc_clr),
        .acc_push  (acc_push),
        .acc_wide  (acc_wide),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err)
    );

    memacc_decode #(.RAM_BYTES(RAM_BYTES)) u_decode (
        .addr   (cur_addr),
        .region (region)
    );

    memacc_port #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u_port (
        .issue     (issue),
        .in_wait   (in_wait),
        .wait_rom  (wait_rom),
        .region    (region),
        .cur_addr  (cur_addr),
        .wr        (wr),
        .wide      (wide),
        .wbyte     (wbyte),
        .wword     (wword),
        .ram_rdata (ram_rdata),
        .rom_rdata (rom_rdata),
        .dev_ready (dev_ready),
        .dev_rdata (dev_rdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .dev_valid (dev_valid),
        .dev_write (dev_write),
        .dev_word  (dev_word),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata),
        .step_done (step_done),
        .step_wait (step_wait),
        .rd_val    (rd_val)
    );

    memacc_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (acc_clr),
        .push      (acc_push),
        .push_wide (acc_wide),
        .val       (rd_val),
        .acc       (rsp_rdata)
    );

    // R11: completion is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10: the error flag first rises only together with done.
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_err) |-> rsp_done);

    // R1: at most one target port is strobed in any cycle.
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_en, rom_en, dev_valid}));

    // R9: a device transfer holds address and width until ready.
    a_r9_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_addr) && $stable(dev_word)));

    // R7: a local memory read is followed by a capture cycle, never by done.
    a_r7_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_en && !ram_we) || rom_en) |=> !rsp_done);

endmodule

// File: tb/memacc_unit_bench.sv
// Directed bench for the sized memory access decoder.
module memacc_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_BYTES  = 1024;
    localparam int RAM_AW     = 10;
    localparam int ROM_AW     = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [23:0]       req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_done;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic              ram_en;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;
    logic              rom_en;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        rom_rdata;
    logic              dev_valid;
    logic              dev_write;
    logic              dev_word;
    logic [23:0]       dev_addr;
    logic [15:0]       dev_wdata;
    logic [15:0]       dev_rdata;
    logic              dev_ready;

    int checks = 0;
    int fails  = 0;
    int n_ram_rd = 0;
    int n_ram_wr = 0;
    int n_rom = 0;
    int n_dev = 0;
    int n_dev_word = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memacc_unit #(.RAM_BYTES(RAM_BYTES), .ROM_AW(ROM_AW)) u_memacc_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .dev_valid(dev_valid), .dev_write(dev_write), .dev_word(dev_word),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_ready(dev_ready)
    );

    // ROM contents as a function of the offset.
    function automatic logic [7:0] rb(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'hC3;
    endfunction

    // Synchronous ROM model.
    always_ff @(posedge clk) begin
        if (rom_en) rom_rdata <= rb(rom_addr);
    end

    // Synchronous RAM model.
    logic [7:0] ram_mem [RAM_BYTES];
    initial begin
        for (int i = 0; i < RAM_BYTES; i++) ram_mem[i] = 8'(i) ^ 8'h3C;
    end
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= ram_mem[ram_addr];
        end
    end

    // Device model: 16 big-endian words, ready one cycle after valid.
    logic [15:0] dev_mem [16];
    initial begin
        for (int i = 0; i < 16; i++) dev_mem[i] = 16'(16'hA000 + i * 273);
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            dev_ready <= 1'b0;
        end else if (dev_valid && !dev_ready) begin
            dev_ready <= 1'b1;
            if (dev_word)         dev_rdata <= dev_mem[dev_addr[4:1]];
            else if (dev_addr[0]) dev_rdata <= {8'h00, dev_mem[dev_addr[4:1]][7:0]};
            else                  dev_rdata <= {8'h00, dev_mem[dev_addr[4:1]][15:8]};
        end else begin
            dev_ready <= 1'b0;
            if (dev_valid && dev_ready && dev_write) begin
                if (dev_word)         dev_mem[dev_addr[4:1]] <= dev_wdata;
                else if (dev_addr[0]) dev_mem[dev_addr[4:1]][7:0] <= dev_wdata[7:0];
                else                  dev_mem[dev_addr[4:1]][15:8] <= dev_wdata[7:0];
            end
        end
    end

    // Port activity counters.
    always @(posedge clk) begin
        if (rst_n) begin
            if (ram_en && ram_we) n_ram_wr++;
            if (ram_en && !ram_we) n_ram_rd++;
            if (rom_en) n_rom++;
            if (dev_valid && dev_ready) begin
                n_dev++;
                if (dev_word) n_dev_word++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; returns read data, error flag and cycles to done.
    task automatic access(input logic [23:0] a, input logic [1:0] sz, input logic w,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic t_reset();
        chk("R1 done in reset", 32'(rsp_done), 32'h0);
        chk("R1 strobes in reset", {29'b0, ram_en, rom_en, dev_valid}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 idle after reset", {28'b0, rsp_done, ram_en, rom_en, dev_valid}, 32'h0);
    endtask

    task automatic t_boot();
        logic [31:0] rd; logic er; int c;
        access(24'h000005, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R2 overlay byte", rd, {24'h0, rb(17'h5)});
        access(24'h000004, 2'd2, 1'b0, 32'h0, rd, er, c);
        chk("R2 overlay long", rd, {rb(17'h4), rb(17'h5), rb(17'h6), rb(17'h7)});
    endtask

    task automatic t_discard();
        logic [31:0] rd; logic er; int c; int w0;
        w0 = n_ram_wr;
        access(24'h000003, 2'd0, 1'b1, 32'h55, rd, er, c);
        access(24'h7E0100, 2'd1, 1'b1, 32'h1234, rd, er, c);
        chk("R3 no RAM strobe on ROM writes", 32'(n_ram_wr - w0), 32'h0);
        access(24'h000003, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R3 overlay unchanged", rd, {24'h0, rb(17'h3)});
        access(24'h7E0100, 2'd1, 1'b0, 32'h0, rd, er, c);
        chk("R6 ROM window word", rd, {16'h0, rb(17'h100), rb(17'h101)});
        access(24'h7E0010, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R6 ROM window byte", rd, {24'h0, rb(17'h10)});
    endtask

    task automatic t_ram();
        logic [31:0] rd; logic er; int c; int w0;
        access(24'h000010, 2'd0, 1'b1, 32'h5A, rd, er, c);
        access(24'h000010, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R4 RAM byte readback", rd, 32'h5A);
        w0 = n_ram_wr;
        access(24'h000100, 2'd1, 1'b1, 32'hBEEF, rd, er, c);
        chk("R7 word write is two bytes", 32'(n_ram_wr - w0), 32'd2);
        access(24'h000100, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R7 MSB at low address", rd, 32'hBE);
        access(24'h000101, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R7 LSB at high address", rd, 32'hEF);
        access(24'h000200, 2'd2, 1'b1, 32'h11223344, rd, er, c);
        access(24'h000200, 2'd1, 1'b0, 32'h0, rd, er, c);
        chk("R8 upper word at addr", rd, 32'h1122);
        access(24'h000202, 2'd1, 1'b0, 32'h0, rd, er, c);
        chk("R8 lower word at addr+2", rd, 32'h3344);
        access(24'h000200, 2'd2, 1'b0, 32'h0, rd, er, c);
        chk("R8 long readback", rd, 32'h11223344);
    endtask

    task automatic t_hole();
        logic [31:0] rd; logic er; int c; int w0;
        access(24'h0003FF, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R4 last populated byte", rd, 32'hC3);
        access(24'h000400, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R5 first unpopulated byte", rd, 32'hFF);
        access(24'h500000, 2'd2, 1'b0, 32'h0, rd, er, c);
        chk("R5 unpopulated long", rd, 32'hFFFFFFFF);
        w0 = n_ram_wr;
        access(24'h000400, 2'd1, 1'b1, 32'h7777, rd, er, c);
        chk("R5 unpopulated write dropped", 32'(n_ram_wr - w0), 32'h0);
    endtask

    task automatic t_dev();
        logic [31:0] rd; logic er; int c; int d0; int dw0;
        d0 = n_dev; dw0 = n_dev_word;
        access(24'h800010, 2'd1, 1'b1, 32'h1234, rd, er, c);
        chk("R9 device word is one transfer", 32'(n_dev - d0), 32'd1);
        chk("R9 device word flag", 32'(n_dev_word - dw0), 32'd1);
        access(24'h800010, 2'd1, 1'b0, 32'h0, rd, er, c);
        chk("R9 device word readback", rd, 32'h1234);
        d0 = n_dev; dw0 = n_dev_word;
        access(24'h800011, 2'd0, 1'b0, 32'h0, rd, er, c);
        chk("R9 device byte", rd, 32'h34);
        chk("R9 device byte not word", 32'(n_dev_word - dw0), 32'h0);
        d0 = n_dev; dw0 = n_dev_word;
        access(24'h800010, 2'd2, 1'b0, 32'h0, rd, er, c);
        chk("R8 device long value", rd, 32'h1234A999);
        chk("R8 device long two word transfers", 32'(n_dev_word - dw0), 32'd2);
    endtask

    task automatic t_straddle();
        logic [31:0] rd; logic er; int c;
        access(24'h7FFFFE, 2'd2, 1'b0, 32'h0, rd, er, c);
        chk("R8 straddling long", rd, {rb(17'h1FFFE), rb(17'h1FFFF), 16'hA000});
    endtask

    task automatic t_badsize();
        logic [31:0] rd; logic er; int c; int s0;
        s0 = n_ram_rd + n_ram_wr + n_rom + n_dev;
        access(24'h000100, 2'd3, 1'b1, 32'hDEAD, rd, er, c);
        chk("R10 error flag", 32'(er), 32'h1);
        chk("R10 latency one cycle", 32'(c), 32'd1);
        chk("R10 no bus activity", 32'(n_ram_rd + n_ram_wr + n_rom + n_dev - s0), 32'h0);
    endtask

    task automatic t_done();
        logic [31:0] rd; logic er; int c;
        access(24'h000100, 2'd1, 1'b0, 32'h0, rd, er, c);
        chk("R11 valid size clears error", 32'(er), 32'h0);
        chk("R11 word right-aligned", rd, 32'hBEEF);
        @(negedge clk);
        chk("R11 done lasts one cycle", 32'(rsp_done), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_boot();
        t_discard();
        t_ram();
        t_hole();
        t_dev();
        t_straddle();
        t_badsize();
        t_done();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule